// File: doc/BRIEF.md
# UART FIFO Control and Trigger Logic

This block is the FIFO-control slice of one channel of a 16550-style serial port. It owns a receive byte queue and a transmit byte queue and takes writes to an 8-bit FIFO control register. Each write sets the queue enable and stores a readable but inert DMA-mode flag. It also stores a receive trigger code and a transmit trigger code, and can pulse self-clearing flushes of either queue. The serial shifters, baud timing and line status sit outside the block. They push into the receive queue and pop from the transmit queue through plain strobes.

A separate 2-bit table-select input chooses between two trigger maps. The block compares the live queue levels against the selected thresholds. It drives a receive-trigger flag and a transmit-room flag that the interrupt and DMA logic elsewhere can use. While the queues are disabled, each one holds a single byte and both thresholds collapse to one.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: After reset the control readback is 0x00, both levels are 0, `rx_trig_hit` is 0 and `tx_room_ok` is 1.
- R2: A write with bit 0 set stores enable=1, the DMA flag from bit 3, the receive code from bits [7:6] and the transmit code from bits [5:4]. The readback is {rx code, tx code, DMA, 0, 0, enable}, so the flush bits 2 and 1 always read 0. The DMA flag changes no level or flag.
- R3: A write with bit 0 clear only clears the enable. Bits 7..1 of that write are ignored: stored codes and DMA flag are kept and no flush happens.
- R4: A write with bits 0 and 1 set empties the receive queue in the following cycle and leaves the transmit queue untouched.
- R5: A write with bits 0 and 2 set empties the transmit queue in the following cycle and leaves the receive queue untouched.
- R6: While enabled, each queue holds up to 64 bytes in first-in first-out order. Its level counts the stored bytes, and the head byte is shown on the data output.
- R7: A push to a full queue or a pop from an empty queue is dropped. It raises that queue's error output for exactly the next cycle.
- R8: While disabled, each queue holds at most one byte.
- R9: Any change of the stored enable empties both queues.
- R10: With table select 00, receive codes 00/01/10/11 give thresholds 1/4/8/14, and the transmit threshold is 1.
- R11: With table select 01, receive codes 00/01/10/11 give thresholds 8/16/24/28. Table selects 10 and 11 act like 00.
- R12: `rx_trig_hit` is 1 while the receive level is at or above its threshold. `tx_room_ok` is 1 while free transmit space is at or above its threshold. With table select 01, transmit codes 00/01/10/11 give 16/8/24/30.
- R13: While disabled, both thresholds are 1 and free space is measured against a capacity of one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fcr_we | input | 1 | Control register write strobe |
| fcr_wdata | input | 8 | Control register write data |
| tbl_sel | input | 2 | Trigger table select |
| ctl_rdata | output | 8 | Control register readback |
| rx_push | input | 1 | Receive queue push |
| rx_din | input | 8 | Receive byte in |
| rx_pop | input | 1 | Receive queue pop |
| rx_dout | output | 8 | Receive queue head byte |
| rx_level | output | 7 | Receive queue level |
| rx_err | output | 1 | Receive overflow/underflow pulse |
| tx_push | input | 1 | Transmit queue push |
| tx_din | input | 8 | Transmit byte in |
| tx_pop | input | 1 | Transmit queue pop |
| tx_dout | output | 8 | Transmit queue head byte |
| tx_level | output | 7 | Transmit queue level |
| tx_err | output | 1 | Transmit overflow/underflow pulse |
| rx_trig_hit | output | 1 | Receive level at or above threshold |
| tx_room_ok | output | 1 | Transmit free space at or above threshold |

## Verification
A register write, push, pop or flush lands on the first rising edge after it is presented. The readback, the levels and the head bytes show it right after that edge. The two trigger flags are combinational from those registers and the table select, so they share that same cycle. The error outputs are registered along with the queue state and are high for only that one following cycle. The bench presents each stimulus at a falling edge and samples on the next falling edge. It then samples once more, one cycle later, to confirm that the error pulses have dropped.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

  typedef struct packed {
    logic [1:0] rx_code;
    logic [1:0] tx_code;
    logic       dma;
    logic       en;
  } fifo_cfg_t;

  localparam logic [1:0] TBL_ALT = 2'b01;

  // receive threshold for a table/code pair
  function automatic logic [7:0] rx_thr_lookup(input logic [1:0] tbl, input logic [1:0] code);
    logic [7:0] v;
    if (tbl == TBL_ALT) begin
      case (code)
        2'd0:    v = 8'd8;
        2'd1:    v = 8'd16;
        2'd2:    v = 8'd24;
        default: v = 8'd28;
      endcase
    end else begin
      case (code)
        2'd0:    v = 8'd1;
        2'd1:    v = 8'd4;
        2'd2:    v = 8'd8;
        default: v = 8'd14;
      endcase
    end
    return v;
  endfunction

  // transmit threshold (free slots) for a table/code pair
  function automatic logic [7:0] tx_thr_lookup(input logic [1:0] tbl, input logic [1:0] code);
    logic [7:0] v;
    if (tbl == TBL_ALT) begin
      case (code)
        2'd0:    v = 8'd16;
        2'd1:    v = 8'd8;
        2'd2:    v = 8'd24;
        default: v = 8'd30;
      endcase
    end else begin
      v = 8'd1;
    end
    return v;
  endfunction

endpackage

// File: rtl/fifo_ctl_reg.sv
module fifo_ctl_reg
  import uart_fifo_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wdata,
  output fifo_cfg_t  cfg,
  output logic       rx_clr,
  output logic       tx_clr,
  output logic [7:0] rdata
);

  fifo_cfg_t cfg_q, cfg_d;
  logic      en_flip;
  logic      accept;

  assign accept = we & wdata[0];

  always_comb begin
    cfg_d = cfg_q;
    if (we) begin
      if (wdata[0]) begin
        cfg_d.rx_code = wdata[7:6];
        cfg_d.tx_code = wdata[5:4];
        cfg_d.dma     = wdata[3];
        cfg_d.en      = 1'b1;
      end else begin
        cfg_d.en      = 1'b0;
      end
    end
  end

  assign en_flip = cfg_d.en ^ cfg_q.en;
  assign rx_clr  = (accept & wdata[1]) | en_flip;
  assign tx_clr  = (accept & wdata[2]) | en_flip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (we) cfg_q <= cfg_d;
  end

  assign cfg   = cfg_q;
  assign rdata = {cfg_q.rx_code, cfg_q.tx_code, cfg_q.dma, 2'b00, cfg_q.en};

  // R3: a write without bit 0 keeps the upper fields and leaves enable low
  p_hold_when_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !wdata[0]) |=> (rdata[7:1] == $past(rdata[7:1])) && !rdata[0]);

  // R2: an accepted write lands its fields in the readback
  p_accept_fields_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wdata[0]) |=> (rdata == {$past(wdata[7:3]), 3'b001}));

endmodule

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [LW-1:0] cap,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic [LW-1:0] level,
  output logic          err
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [LW-1:0] lvl_q, lvl_d;
  logic          err_q, err_d;
  logic          full, empty, push_ok, pop_ok;

  assign full    = (lvl_q >= cap);
  assign empty   = (lvl_q == '0);
  assign push_ok = push & ~full & ~clr;
  assign pop_ok  = pop & ~empty & ~clr;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    lvl_d = lvl_q;
    err_d = 1'b0;
    if (clr) begin
      wr_d  = '0;
      rd_d  = '0;
      lvl_d = '0;
    end else begin
      if (push_ok) wr_d = wr_q + AW'(1);
      if (pop_ok)  rd_d = rd_q + AW'(1);
      case ({push_ok, pop_ok})
        2'b10:   lvl_d = lvl_q + LW'(1);
        2'b01:   lvl_d = lvl_q - LW'(1);
        default: lvl_d = lvl_q;
      endcase
      err_d = (push & full) | (pop & empty);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
      err_q <= 1'b0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      lvl_q <= lvl_d;
      err_q <= err_d;
    end
  end

  // storage array: write enable only, no reset
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= din;
  end

  assign dout  = mem[rd_q];
  assign level = lvl_q;
  assign err   = err_q;

  // R6: the level never passes the physical depth
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

  // R4: a flush leaves the queue empty with no error
  p_flush_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (level == '0) && !err);

  // R7: a push into a full queue is dropped and flagged
  p_full_push_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !clr && level >= cap) |=> err && $stable(level));

  // R7: a pop from an empty queue is dropped and flagged
  p_empty_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !clr && level == '0) |=> err && (level == '0));

endmodule

// File: rtl/trig_sel.sv
module trig_sel
  import uart_fifo_pkg::*;
#(
  parameter int unsigned LW = 7
) (
  input  fifo_cfg_t     cfg,
  input  logic [1:0]    tbl,
  input  logic [LW-1:0] cap,
  input  logic [LW-1:0] rx_level,
  input  logic [LW-1:0] tx_level,
  output logic          rx_hit,
  output logic          tx_ok
);

  logic [LW-1:0] rx_thr, tx_thr, tx_room;

  always_comb begin
    if (cfg.en) begin
      rx_thr = LW'(rx_thr_lookup(tbl, cfg.rx_code));
      tx_thr = LW'(tx_thr_lookup(tbl, cfg.tx_code));
    end else begin
      rx_thr = LW'(1);
      tx_thr = LW'(1);
    end
  end

  assign tx_room = cap - tx_level;
  assign rx_hit  = (rx_level >= rx_thr);
  assign tx_ok   = (tx_room >= tx_thr);

endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
  import uart_fifo_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned LW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fcr_we,
  input  logic [7:0]    fcr_wdata,
  input  logic [1:0]    tbl_sel,
  output logic [7:0]    ctl_rdata,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_din,
  input  logic          rx_pop,
  output logic [DW-1:0] rx_dout,
  output logic [LW-1:0] rx_level,
  output logic          rx_err,
  input  logic          tx_push,
  input  logic [DW-1:0] tx_din,
  input  logic          tx_pop,
  output logic [DW-1:0] tx_dout,
  output logic [LW-1:0] tx_level,
  output logic          tx_err,
  output logic          rx_trig_hit,
  output logic          tx_room_ok
);

  fifo_cfg_t     cfg;
  logic          rx_clr, tx_clr;
  logic [LW-1:0] cap;

  fifo_ctl_reg u_ctl (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (fcr_we),
    .wdata  (fcr_wdata),
    .cfg    (cfg),
    .rx_clr (rx_clr),
    .tx_clr (tx_clr),
    .rdata  (ctl_rdata)
  );

  assign cap = cfg.en ? LW'(DEPTH) : LW'(1);

  byte_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (rx_clr),
    .cap   (cap),
    .push  (rx_push),
    .din   (rx_din),
    .pop   (rx_pop),
    .dout  (rx_dout),
    .level (rx_level),
    .err   (rx_err)
  );

  byte_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tx_clr),
    .cap   (cap),
    .push  (tx_push),
    .din   (tx_din),
    .pop   (tx_pop),
    .dout  (tx_dout),
    .level (tx_level),
    .err   (tx_err)
  );

  trig_sel #(.LW(LW)) u_trig (
    .cfg      (cfg),
    .tbl      (tbl_sel),
    .cap      (cap),
    .rx_level (rx_level),
    .tx_level (tx_level),
    .rx_hit   (rx_trig_hit),
    .tx_ok    (tx_room_ok)
  );

  // R8: a disabled queue never holds more than one byte
  p_single_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rdata[0] |-> (rx_level <= LW'(1)) && (tx_level <= LW'(1)));

  // R13: with the queues off both flags reduce to occupancy checks
  p_off_flags_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rdata[0] |-> (rx_trig_hit == (rx_level != '0)) && (tx_room_ok == (tx_level == '0)));

  // R9: an enable change empties both queues
  p_en_flip_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[0] != $past(ctl_rdata[0])) |-> (rx_level == '0) && (tx_level == '0));

endmodule

// File: tb/sim_uart_fifo_ctrl.sv
module sim_uart_fifo_ctrl;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       fcr_we;
  logic [7:0] fcr_wdata;
  logic [1:0] tbl_sel;
  logic [7:0] ctl_rdata;
  logic       rx_push, rx_pop, tx_push, tx_pop;
  logic [7:0] rx_din, tx_din, rx_dout, tx_dout;
  logic [6:0] rx_level, tx_level;
  logic       rx_err, tx_err, rx_trig_hit, tx_room_ok;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_fifo_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .fcr_we(fcr_we), .fcr_wdata(fcr_wdata),
    .tbl_sel(tbl_sel), .ctl_rdata(ctl_rdata),
    .rx_push(rx_push), .rx_din(rx_din), .rx_pop(rx_pop), .rx_dout(rx_dout),
    .rx_level(rx_level), .rx_err(rx_err),
    .tx_push(tx_push), .tx_din(tx_din), .tx_pop(tx_pop), .tx_dout(tx_dout),
    .tx_level(tx_level), .tx_err(tx_err),
    .rx_trig_hit(rx_trig_hit), .tx_room_ok(tx_room_ok)
  );

  typedef struct packed {
    logic [1:0] tbl;
    logic [1:0] rxc;
    logic [1:0] txc;
    logic [6:0] fill;
    logic       rx_exp;
    logic       tx_exp;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd0, 2'd0, 7'd0,  1'b0, 1'b1},
    '{2'd0, 2'd0, 2'd0, 7'd1,  1'b1, 1'b1},
    '{2'd0, 2'd1, 2'd0, 7'd3,  1'b0, 1'b1},
    '{2'd0, 2'd1, 2'd0, 7'd4,  1'b1, 1'b1},
    '{2'd0, 2'd2, 2'd0, 7'd7,  1'b0, 1'b1},
    '{2'd0, 2'd3, 2'd0, 7'd14, 1'b1, 1'b1},
    '{2'd0, 2'd3, 2'd0, 7'd13, 1'b0, 1'b1},
    '{2'd1, 2'd0, 2'd0, 7'd8,  1'b1, 1'b1},
    '{2'd1, 2'd1, 2'd0, 7'd15, 1'b0, 1'b1},
    '{2'd1, 2'd2, 2'd2, 7'd40, 1'b1, 1'b1},
    '{2'd1, 2'd2, 2'd2, 7'd41, 1'b1, 1'b0},
    '{2'd1, 2'd3, 2'd3, 7'd34, 1'b1, 1'b1},
    '{2'd1, 2'd3, 2'd3, 7'd35, 1'b1, 1'b0},
    '{2'd1, 2'd3, 2'd1, 7'd27, 1'b0, 1'b1},
    '{2'd1, 2'd0, 2'd1, 7'd57, 1'b1, 1'b0},
    '{2'd2, 2'd1, 2'd0, 7'd3,  1'b0, 1'b1},
    '{2'd3, 2'd3, 2'd3, 7'd63, 1'b1, 1'b1},
    '{2'd0, 2'd0, 2'd0, 7'd64, 1'b1, 1'b0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic idle_strobes();
    fcr_we = 1'b0; rx_push = 1'b0; rx_pop = 1'b0; tx_push = 1'b0; tx_pop = 1'b0;
  endtask

  task automatic wr_fcr(input logic [7:0] v);
    fcr_we = 1'b1; fcr_wdata = v;
    @(negedge clk);
    idle_strobes();
  endtask

  task automatic push_both(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      rx_push = 1'b1; tx_push = 1'b1;
      rx_din = base + 8'(i); tx_din = ~(base + 8'(i));
      @(negedge clk);
    end
    idle_strobes();
  endtask

  task automatic step(input logic rp, input logic rq, input logic tp, input logic tq, input logic [7:0] d);
    rx_push = rp; rx_pop = rq; tx_push = tp; tx_pop = tq; rx_din = d; tx_din = d;
    @(negedge clk);
    idle_strobes();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tbl_sel = 2'd0; fcr_wdata = 8'h00; rx_din = 8'h00; tx_din = 8'h00;
    idle_strobes();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 rdata", ctl_rdata, 0);
    chk("R1 rx_level", rx_level, 0);
    chk("R1 tx_level", tx_level, 0);
    chk("R1 rx_trig_hit", rx_trig_hit, 0);
    chk("R1 tx_room_ok", tx_room_ok, 1);

    // R8 / R13: disabled single-byte holding
    step(1'b1, 1'b0, 1'b1, 1'b0, 8'hA1);
    chk("R8 rx_level one", rx_level, 1);
    chk("R13 rx_trig_hit at 1", rx_trig_hit, 1);
    chk("R13 tx_room_ok full", tx_room_ok, 0);
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'hA2);
    chk("R8 rx_level still one", rx_level, 1);
    chk("R8 rx head kept", rx_dout, 8'hA1);
    chk("R7 rx_err on full", rx_err, 1);
    @(negedge clk);
    chk("R7 rx_err one cycle", rx_err, 0);

    // R3: bits ignored while bit 0 is low, no flush
    wr_fcr(8'h06);
    chk("R3 no flush rx", rx_level, 1);
    chk("R3 no flush tx", tx_level, 1);
    chk("R3 rdata", ctl_rdata, 0);

    // R9: enabling empties both
    wr_fcr(8'h01);
    chk("R9 rx empty", rx_level, 0);
    chk("R9 tx empty", tx_level, 0);

    // R2: field storage and readback
    wr_fcr(8'hB9);
    chk("R2 rdata", ctl_rdata, 8'hB9);
    wr_fcr(8'hBF);
    chk("R2 flush bits read 0", ctl_rdata, 8'hB9);
    wr_fcr(8'hB1);
    chk("R2 dma cleared", ctl_rdata, 8'hB1);
    // R3: disable keeps fields
    wr_fcr(8'h40);
    chk("R3 fields kept", ctl_rdata, 8'hB0);
    wr_fcr(8'h01);
    chk("R2 re-enable", ctl_rdata, 8'h01);

    // R6 / R7: full depth, order, overflow, underflow
    push_both(64, 8'h10);
    chk("R6 rx_level 64", rx_level, 64);
    chk("R6 tx_level 64", tx_level, 64);
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'hEE);
    chk("R7 overflow level", rx_level, 64);
    chk("R7 overflow err", rx_err, 1);
    chk("R7 tx no err", tx_err, 0);
    for (int i = 0; i < 64; i++) begin
      chk("R6 rx order", rx_dout, 8'h10 + i);
      chk("R6 tx order", tx_dout, 8'(~(8'h10 + 8'(i))));
      step(1'b0, 1'b1, 1'b0, 1'b1, 8'h00);
    end
    chk("R6 rx drained", rx_level, 0);
    step(1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
    chk("R7 underflow err", rx_err, 1);
    chk("R7 underflow level", rx_level, 0);
    @(negedge clk);
    chk("R7 err drops", rx_err, 0);

    // R4 / R5: independent flushes
    push_both(5, 8'h30);
    wr_fcr(8'h03);
    chk("R4 rx flushed", rx_level, 0);
    chk("R4 tx kept", tx_level, 5);
    push_both(2, 8'h40);
    wr_fcr(8'h05);
    chk("R5 tx flushed", tx_level, 0);
    chk("R5 rx kept", rx_level, 2);
    chk("R5 rx head", rx_dout, 8'h40);

    // R10 / R11 / R12: trigger table walk
    for (int v = 0; v < NV; v++) begin
      wr_fcr({VECS[v].rxc, VECS[v].txc, 4'b0111});
      tbl_sel = VECS[v].tbl;
      push_both(int'(VECS[v].fill), 8'h00);
      chk((VECS[v].tbl == 2'd0) ? "R10 rx_trig_hit" : "R11 rx_trig_hit", rx_trig_hit, VECS[v].rx_exp);
      chk("R12 tx_room_ok", tx_room_ok, VECS[v].tx_exp);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule